// File: doc/BRIEF.md
# Bit-Addressable GPIO Port Controller

An eight-pin general-purpose I/O port behind a small register bus. Software programs a direction register and an output data register, and reads back the pad levels through a synchronized input register. For each pin the block drives an output enable, an output value and a pull-up enable to the pad cell.

Software can set or clear one bit of the direction or data register without a read-modify-write, so other pins are never disturbed. Writing ones to the input register inverts the matching output data bits. A global pull-up disable input turns off every pull-up. Each pin has an alternate-function override, so a peripheral can take that pad without touching the other seven pins.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and data registers read 0x00, and every bit of pad_oe, pad_out and pad_pu is 0.
- R2: bus_addr selects a register: 0 is the input register (read-only), 1 is direction and 2 is data (both read/write). Address 3 reads 0x00, and a write to it changes no register.
- R3: A bus write to address 0 inverts each data register bit whose bus_wdata bit is 1. Bits written as 0 keep their value.
- R4: bit_set for one cycle sets bit bit_idx of the register chosen by bit_sel (0 = direction, 1 = data). All other bits of both registers stay unchanged.
- R5: bit_clr for one cycle clears bit bit_idx of the register chosen by bit_sel. If bit_set and bit_clr are both asserted, the bit is cleared.
- R6: If a bit operation and a bus write or toggle hit the same register in the same cycle, the bit operation decides the addressed bit. The remaining bits take the bus write or toggle.
- R7: A read of address 0 returns pad_in as sampled two rising clock edges earlier.
- R8: When alt_en[n] is 0, pad_oe[n] equals direction bit n and pad_out[n] equals data bit n. When alt_en[n] is 1, pad_oe[n] follows alt_oe[n] and pad_out[n] follows alt_out[n]. Other pins are unaffected.
- R9: pad_pu[n] is 1 only when direction bit n is 0, data bit n is 1, alt_en[n] is 0 and pud is 0.
- R10: While pud is 1, every pad_pu bit is 0, whatever the register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| bit_set | input | 1 | Set one bit |
| bit_clr | input | 1 | Clear one bit |
| bit_sel | input | 1 | Bit-operation target: 0 direction, 1 data |
| bit_idx | input | 3 | Bit-operation index |
| pud | input | 1 | Global pull-up disable |
| alt_en | input | 8 | Per-pin alternate-function override |
| alt_oe | input | 8 | Alternate output enable |
| alt_out | input | 8 | Alternate output value |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |

## Verification
Register writes and bit operations take effect at the rising edge that samples them. The pad outputs and read data follow combinationally, so the bench drives stimulus after a falling edge and checks at the next falling edge. A change on pad_in reaches the input register after two rising edges. The bench checks that the old value is still present after one edge and that the new value is present after the second. Changes to pud and the alternate-function inputs need no edge, and their effects are checked a short delay after the inputs are driven.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    RSEL_PINS = 2'd0,
    RSEL_DIR  = 2'd1,
    RSEL_DATA = 2'd2,
    RSEL_NONE = 2'd3
  } rsel_e;
endpackage

// File: rtl/gpio_bitreg.sv
module gpio_bitreg #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          tgl_en,
  input  logic [W-1:0]  tgl_mask,
  input  logic          bit_set,
  input  logic          bit_clr,
  input  logic [IW-1:0] bit_idx,
  output logic [W-1:0]  q
);
  logic [W-1:0] nxt;
  logic         upd;

  always_comb begin
    nxt = q;
    if (wr_en)   nxt = wr_data;
    if (tgl_en)  nxt = nxt ^ tgl_mask;
    if (bit_set) nxt[bit_idx] = 1'b1;
    if (bit_clr) nxt[bit_idx] = 1'b0;
  end

  assign upd = wr_en | tgl_en | bit_set | bit_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= nxt;
  end

  assert_set_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_set && !bit_clr && !wr_en && !tgl_en)
    |=> (q == ($past(q) | (W'(1) << $past(bit_idx)))));

  assert_clr_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_set && bit_clr) |=> (q[$past(bit_idx)] == 1'b0));

  assert_toggle_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_en && !wr_en && !bit_set && !bit_clr) |=> (q == ($past(q) ^ $past(tgl_mask))));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assign dout = s2_q;

  assert_two_edge_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] data,
  input  logic         pud,
  input  logic [W-1:0] alt_en,
  input  logic [W-1:0] alt_oe,
  input  logic [W-1:0] alt_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  for (genvar n = 0; n < W; n++) begin : g_pin
    always_comb begin
      if (alt_en[n]) begin
        pad_oe[n]  = alt_oe[n];
        pad_out[n] = alt_out[n];
        pad_pu[n]  = 1'b0;
      end else begin
        pad_oe[n]  = dir[n];
        pad_out[n] = data[n];
        pad_pu[n]  = ~dir[n] & data[n] & ~pud;
      end
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          bit_set,
  input  logic          bit_clr,
  input  logic          bit_sel,
  input  logic [IW-1:0] bit_idx,
  input  logic          pud,
  input  logic [W-1:0]  alt_en,
  input  logic [W-1:0]  alt_oe,
  input  logic [W-1:0]  alt_out,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_pu
);
  import gpio_port_pkg::*;

  rsel_e        rsel;
  logic [W-1:0] dir_q;
  logic [W-1:0] data_q;
  logic [W-1:0] pins_q;
  logic         dir_wr;
  logic         data_wr;
  logic         pins_wr;

  assign rsel    = rsel_e'(bus_addr);
  assign dir_wr  = bus_we && (rsel == RSEL_DIR);
  assign data_wr = bus_we && (rsel == RSEL_DATA);
  assign pins_wr = bus_we && (rsel == RSEL_PINS);

  gpio_bitreg #(.W(W)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dir_wr), .wr_data(bus_wdata),
    .tgl_en(1'b0), .tgl_mask('0),
    .bit_set(bit_set && !bit_sel), .bit_clr(bit_clr && !bit_sel),
    .bit_idx(bit_idx), .q(dir_q)
  );

  gpio_bitreg #(.W(W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_en(data_wr), .wr_data(bus_wdata),
    .tgl_en(pins_wr), .tgl_mask(bus_wdata),
    .bit_set(bit_set && bit_sel), .bit_clr(bit_clr && bit_sel),
    .bit_idx(bit_idx), .q(data_q)
  );

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pins_q)
  );

  gpio_pad_ctrl #(.W(W)) u_pads (
    .dir(dir_q), .data(data_q), .pud(pud),
    .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  always_comb begin
    unique case (rsel)
      RSEL_PINS: bus_rdata = pins_q;
      RSEL_DIR:  bus_rdata = dir_q;
      RSEL_DATA: bus_rdata = data_q;
      default:   bus_rdata = '0;
    endcase
  end

  assert_pud_kills_pullups_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pud |-> (pad_pu == '0));

  assert_alt_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~alt_en) == (dir_q & ~alt_en)) && ((pad_out & ~alt_en) == (data_q & ~alt_en)));

  assert_pullup_input_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & (dir_q | ~data_q | alt_en)) == '0));

  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (rsel == RSEL_NONE) && !bit_set && !bit_clr)
    |=> ($stable(dir_q) && $stable(data_q)));
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       bit_set, bit_clr, bit_sel;
  logic [2:0] bit_idx;
  logic       pud;
  logic [7:0] alt_en, alt_oe, alt_out, pad_in;
  logic [7:0] pad_oe, pad_out, pad_pu;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_set(bit_set),
    .bit_clr(bit_clr), .bit_sel(bit_sel), .bit_idx(bit_idx), .pud(pud),
    .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bitop(input logic s, input logic c, input logic sel, input logic [2:0] idx);
    @(negedge clk);
    bit_set = s; bit_clr = c; bit_sel = sel; bit_idx = idx;
    @(negedge clk);
    bit_set = 1'b0; bit_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rd(2'd2, v); chk("R1 data", v, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
  endtask

  task automatic t_map();
    logic [7:0] v;
    wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 dir rw", v, 8'hA5);
    wr(2'd2, 8'h3C); rd(2'd2, v); chk("R2 data rw", v, 8'h3C);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R2 addr3 reads 0", v, 8'h00);
    rd(2'd1, v); chk("R2 addr3 no dir change", v, 8'hA5);
    rd(2'd2, v); chk("R2 addr3 no data change", v, 8'h3C);
  endtask

  task automatic t_toggle();
    logic [7:0] v;
    wr(2'd0, 8'h0F); rd(2'd2, v); chk("R3 toggle", v, 8'h33);
    wr(2'd0, 8'h00); rd(2'd2, v); chk("R3 zero mask", v, 8'h33);
    rd(2'd1, v); chk("R3 dir untouched", v, 8'hA5);
  endtask

  task automatic t_bitops();
    logic [7:0] v;
    bitop(1'b1, 1'b0, 1'b0, 3'd6); rd(2'd1, v); chk("R4 set dir6", v, 8'hE5);
    rd(2'd2, v); chk("R4 data untouched", v, 8'h33);
    bitop(1'b1, 1'b0, 1'b1, 3'd7); rd(2'd2, v); chk("R4 set data7", v, 8'hB3);
    bitop(1'b0, 1'b1, 1'b1, 3'd1); rd(2'd2, v); chk("R5 clr data1", v, 8'hB1);
    bitop(1'b0, 1'b1, 1'b0, 3'd0); rd(2'd1, v); chk("R5 clr dir0", v, 8'hE4);
    bitop(1'b1, 1'b1, 1'b1, 3'd4); rd(2'd2, v); chk("R5 both clears", v, 8'hA1);
  endtask

  task automatic t_prio();
    logic [7:0] v;
    @(negedge clk);
    bus_addr = 2'd2; bus_we = 1'b1; bus_wdata = 8'hFF;
    bit_clr = 1'b1; bit_sel = 1'b1; bit_idx = 3'd0;
    @(negedge clk);
    bus_we = 1'b0; bit_clr = 1'b0;
    rd(2'd2, v); chk("R6 write vs clr", v, 8'hFE);
    @(negedge clk);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 8'h81;
    bit_set = 1'b1; bit_sel = 1'b1; bit_idx = 3'd7;
    @(negedge clk);
    bus_we = 1'b0; bit_set = 1'b0;
    rd(2'd2, v); chk("R6 toggle vs set", v, 8'hFF);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    @(negedge clk); pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h5A;
    @(negedge clk); rd(2'd0, v); chk("R7 one edge old", v, 8'h00);
    @(negedge clk); rd(2'd0, v); chk("R7 two edges new", v, 8'h5A);
    pad_in = 8'hC3;
    @(negedge clk); @(negedge clk); rd(2'd0, v); chk("R7 second value", v, 8'hC3);
  endtask

  task automatic t_pads();
    wr(2'd1, 8'h0F); wr(2'd2, 8'h55);
    chk("R8 oe", pad_oe, 8'h0F);
    chk("R8 out", pad_out, 8'h55);
    alt_en = 8'h08; alt_oe = 8'h00; alt_out = 8'hFF; #1;
    chk("R8 alt oe", pad_oe, 8'h07);
    chk("R8 alt out", pad_out, 8'h5D);
    alt_en = 8'h00; #1;
  endtask

  task automatic t_pull();
    chk("R9 pullups", pad_pu, 8'h50);
    alt_en = 8'h10; #1;
    chk("R9 alt drops pullup", pad_pu, 8'h40);
    alt_en = 8'h00;
    pud = 1'b1; #1;
    chk("R10 pud all off", pad_pu, 8'h00);
    @(negedge clk); wr(2'd2, 8'hFF);
    chk("R10 pud after data write", pad_pu, 8'h00);
    pud = 1'b0; #1;
    chk("R9 pud released", pad_pu, 8'hF0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 2'd0; bus_we = 1'b0; bus_wdata = 8'h00;
    bit_set = 1'b0; bit_clr = 1'b0; bit_sel = 1'b0; bit_idx = 3'd0;
    pud = 1'b0; alt_en = 8'h00; alt_oe = 8'h00; alt_out = 8'h00; pad_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_toggle();
    t_bitops();
    t_prio();
    t_sync();
    t_pads();
    t_pull();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule